// File: doc/BRIEF.md
# Timer Channel Status and Control Register

This block is the software-visible control and status word for one channel of a capture/compare timer. It sits on a simple synchronous register bus that has an address, a read strobe, a write strobe, write data and combinational read data. It drives the channel's configuration outputs: the two mode-select bits, the two edge-select bits, the enable for counter reset on capture, and the DMA enable. It also raises an interrupt request.

A hardware event pulse from the channel sets a sticky event flag. Software clears the flag in two steps. First it reads the register while the flag is 1, which arms the clear. Then it writes 0 to the flag bit. A new event that arrives after the arming read cancels the pending clear, so a later event is never lost. The five configuration bits in the middle of the word change only while the external write-protect-disable input is high. The interrupt-enable bit and the DMA-enable bit can be written at any time.

Top module: `chan_csr`

## Requirements
- R1: Bits DATA_W-1 down to 8 of the read data are always zero, and writes to those bits have no effect.
- R2: A cycle with `chan_evt` high sets the event flag, which reads back in bit 7 from the next cycle.
- R3: Writing 1 to bit 7 never changes the flag.
- R4: A write with bit 7 equal to 0 clears the flag only when it follows a read of this register that returned bit 7 as 1. Without that arming read, the flag stays set.
- R5: A channel event between the arming read and the clearing write cancels the clear. An event in the same cycle as the clearing write keeps the flag at 1.
- R6: `irq` is high exactly while the flag and the interrupt-enable bit (bit 6) are both 1.
- R7: Bits 5..1 drive `mode_sel` = {bit5, bit4}, `edge_sel` = {bit3, bit2} and `crst_en` = bit1. A write updates these bits only while `wp_off` is 1. Otherwise they keep their value.
- R8: Bit 0 drives `dma_en` and is written on every write, whatever the value of `wp_off`.
- R9: `ctr_rst` is high in the same cycle as `chan_evt` when `crst_en` is 1, and is low at all other times.
- R10: A synchronous active-high `rst` sets every field and the flag to zero and drops any arming.
- R11: Any write to the register drops the arming, whether or not it clears the flag.
- R12: Strobes whose `bus_addr` differs from the parameter REG_ADDR change nothing, and such reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational, zero when not selected) |
| chan_evt | input | 1 | Channel event pulse |
| wp_off | input | 1 | High to allow writes to the protected fields |
| mode_sel | output | 2 | Mode-select bits |
| edge_sel | output | 2 | Edge/level-select bits |
| crst_en | output | 1 | Counter reset on capture enable |
| ctr_rst | output | 1 | Counter reset request |
| irq | output | 1 | Interrupt request |
| dma_en | output | 1 | DMA enable |

## Verification
The bench builds the block with the default 32-bit data path and a 4-bit address. It places the register at address 5, so that accesses to every other address can be swept. With wp_off both low and high, it writes all 128 values of the low seven bits. Against an arithmetic model it then covers every combination of the protected and unprotected fields, and every interaction between the flag and the interrupt enable. Directed sequences cover the clear handshake: a clear without arming, a clear after an event, a same-cycle event, and disarming by a write of 1.

// File: rtl/chan_csr_pkg.sv
package chan_csr_pkg;
   localparam int FLAG_BIT = 7;
   localparam int IE_BIT   = 6;
   localparam int CFG_LO   = 1;
   localparam int CFG_HI   = 5;
   localparam int CFG_W    = CFG_HI - CFG_LO + 1;
   localparam int DMA_BIT  = 0;
   localparam int USED_W   = FLAG_BIT + 1;

   typedef struct packed {
      logic [1:0] mode;
      logic [1:0] edge_lvl;
      logic       crst;
   } cfg_t;
endpackage

// File: rtl/chan_csr_field.sv
module chan_csr_field #(
   parameter int W       = 1,
   parameter bit GUARDED = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic         unlock,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic take;

   generate
      if (GUARDED) begin : g_guarded
         assign take = we & unlock;
      end else begin : g_open
         assign take = we;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (take) q <= d;
   end
endmodule

// File: rtl/chan_csr_flag.sv
module chan_csr_flag (
   input  logic clk,
   input  logic rst,
   input  logic evt,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wr_bit,
   output logic flag,
   output logic armed
);
   logic clr_ok;

   assign clr_ok = wr_hit & armed & ~wr_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (evt)         flag <= 1'b1;
         else if (clr_ok) flag <= 1'b0;

         if (wr_hit || evt)     armed <= 1'b0;
         else if (rd_hit && flag) armed <= 1'b1;
      end
   end
endmodule

// File: rtl/chan_csr.sv
module chan_csr
   import chan_csr_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              chan_evt,
   input  logic              wp_off,
   output logic [1:0]        mode_sel,
   output logic [1:0]        edge_sel,
   output logic              crst_en,
   output logic              ctr_rst,
   output logic              irq,
   output logic              dma_en
);
   localparam int PAD_W = DATA_W - USED_W;

   generate
      if (DATA_W < USED_W) begin : g_bad_width
         $error("chan_csr: DATA_W must be at least 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("chan_csr: ADDR_W must be at least 1");
      end
   endgenerate

   logic             sel, rd_hit, wr_hit;
   logic             flag_q, armed_q, ie_q, dma_q;
   logic [CFG_W-1:0] cfg_q;
   cfg_t             cfg_s;
   logic [USED_W-1:0] word;

   assign sel    = (bus_addr == REG_ADDR);
   assign rd_hit = sel & bus_rd;
   assign wr_hit = sel & bus_wr;

   chan_csr_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .evt   (chan_evt),
      .rd_hit(rd_hit),
      .wr_hit(wr_hit),
      .wr_bit(bus_wdata[FLAG_BIT]),
      .flag  (flag_q),
      .armed (armed_q)
   );

   chan_csr_field #(.W(CFG_W), .GUARDED(1'b1)) u_cfg (
      .clk(clk), .rst(rst), .we(wr_hit), .unlock(wp_off),
      .d(bus_wdata[CFG_HI:CFG_LO]), .q(cfg_q)
   );

   chan_csr_field #(.W(1), .GUARDED(1'b0)) u_ie (
      .clk(clk), .rst(rst), .we(wr_hit), .unlock(wp_off),
      .d(bus_wdata[IE_BIT]), .q(ie_q)
   );

   chan_csr_field #(.W(1), .GUARDED(1'b0)) u_dma (
      .clk(clk), .rst(rst), .we(wr_hit), .unlock(wp_off),
      .d(bus_wdata[DMA_BIT]), .q(dma_q)
   );

   assign cfg_s    = cfg_t'(cfg_q);
   assign mode_sel = cfg_s.mode;
   assign edge_sel = cfg_s.edge_lvl;
   assign crst_en  = cfg_s.crst;
   assign dma_en   = dma_q;
   assign irq      = flag_q & ie_q;
   assign ctr_rst  = chan_evt & cfg_s.crst;

   assign word = {flag_q, ie_q, cfg_q, dma_q};

   generate
      if (PAD_W > 0) begin : g_pad
         assign bus_rdata = rd_hit ? {{PAD_W{1'b0}}, word} : '0;
      end else begin : g_nopad
         assign bus_rdata = rd_hit ? word : '0;
      end
   endgenerate
endmodule

// File: rtl/chan_csr_chk.sv
module chan_csr_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              chan_evt,
   input logic              wp_off,
   input logic              wr_hit,
   input logic              wbit7,
   input logic              flag_q,
   input logic              armed_q,
   input logic [1:0]        mode_sel,
   input logic [1:0]        edge_sel,
   input logic              crst_en,
   input logic              ctr_rst,
   input logic              irq
);
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      bus_rdata[DATA_W-1:8] == '0);

   a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
      chan_evt |=> flag_q);

   a_r3_one_keeps: assert property (@(posedge clk) disable iff (rst)
      (flag_q && wr_hit && wbit7) |=> flag_q);

   a_r4_unarmed_keeps: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !armed_q) |=> flag_q);

   a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
      irq |-> flag_q);

   a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
      !wp_off |=> $stable({mode_sel, edge_sel, crst_en}));

   a_r9_ctr_rst_src: assert property (@(posedge clk) disable iff (rst)
      ctr_rst |-> (chan_evt && crst_en));

   a_r11_write_disarms: assert property (@(posedge clk) disable iff (rst)
      wr_hit |=> !armed_q);
endmodule

bind chan_csr chan_csr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_rdata(bus_rdata),
   .chan_evt (chan_evt),
   .wp_off   (wp_off),
   .wr_hit   (wr_hit),
   .wbit7    (bus_wdata[7]),
   .flag_q   (flag_q),
   .armed_q  (armed_q),
   .mode_sel (mode_sel),
   .edge_sel (edge_sel),
   .crst_en  (crst_en),
   .ctr_rst  (ctr_rst),
   .irq      (irq)
);

// File: tb/chan_csr_bench.sv
module chan_csr_bench;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam logic [AW-1:0] RA = 4'd5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] bus_addr = RA;
   logic          bus_rd = 1'b0, bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          chan_evt = 1'b0, wp_off = 1'b0;
   logic [1:0]    mode_sel, edge_sel;
   logic          crst_en, ctr_rst, irq, dma_en;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   chan_csr #(.DATA_W(DW), .ADDR_W(AW), .REG_ADDR(RA)) u_chan_csr (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .chan_evt(chan_evt), .wp_off(wp_off), .mode_sel(mode_sel),
      .edge_sel(edge_sel), .crst_en(crst_en), .ctr_rst(ctr_rst),
      .irq(irq), .dma_en(dma_en)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = RA;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = RA;
   endtask

   task automatic pulse();
      @(negedge clk);
      chan_evt = 1'b1;
      @(negedge clk);
      chan_evt = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] r;
      logic [4:0] cfg_m;
      logic       ie_m, dma_m;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // R10 reset state
      rd(RA, r);
      chk("R10 reset read", r, '0);
      chk("R10 reset outputs", {26'd0, mode_sel, edge_sel, crst_en, irq}, '0);

      // R1 / R3: all ones written with protection off
      wp_off = 1'b1;
      wr(RA, '1);
      rd(RA, r);
      chk("R1 R3 ones write", r, 32'h7F);

      // R7 / R8 / R6 sweep
      cfg_m = 5'h1F; ie_m = 1'b1; dma_m = 1'b1;
      for (int w = 0; w < 2; w++) begin
         wp_off = w[0];
         for (int v = 0; v < 128; v++) begin
            wr(RA, 32'(v) | 32'hFFFF_FF00);
            if (w == 1) cfg_m = 5'(v >> 1);
            ie_m = v[6]; dma_m = v[0];
            rd(RA, r);
            chk("R7 R8 sweep read", r, {24'd0, 1'b0, ie_m, cfg_m, dma_m});
            chk("R7 R8 sweep outputs", {27'd0, mode_sel, edge_sel, crst_en} ^ {26'd0, dma_en, 5'd0},
                {27'd0, cfg_m} ^ {26'd0, dma_m, 5'd0});
            chk("R6 irq idle", {31'd0, irq}, 32'd0);
         end
      end

      // R12 other address ignored
      wp_off = 1'b1;
      wr(RA, 32'h0);
      wr(4'd3, 32'h7F);
      rd(RA, r);
      chk("R12 foreign write", r, 32'h0);
      rd(4'd3, r);
      chk("R12 foreign read", r, 32'h0);

      // R2 / R6 / R9
      wr(RA, 32'h42);  // ie=1, crst_en=1
      @(negedge clk); chan_evt = 1'b1; #1;
      chk("R9 ctr_rst with event", {31'd0, ctr_rst}, 32'd1);
      @(negedge clk); chan_evt = 1'b0; #1;
      chk("R9 ctr_rst idle", {31'd0, ctr_rst}, 32'd0);
      chk("R6 irq raised", {31'd0, irq}, 32'd1);
      rd(RA, r);
      chk("R2 flag set", r, 32'hC2);

      // R4: clear after arming read
      wr(RA, 32'h42);
      rd(RA, r);
      chk("R4 clear armed", r, 32'h42);
      chk("R6 irq dropped", {31'd0, irq}, 32'd0);

      // R4 without arming
      wr(RA, 32'h40);
      pulse();
      wr(RA, 32'h40);
      rd(RA, r);
      chk("R4 unarmed write keeps", r, 32'hC0);

      // R3 write of 1 after arming disarms (R11)
      wr(RA, 32'hC0);
      wr(RA, 32'h40);
      rd(RA, r);
      chk("R11 disarm then zero", r, 32'hC0);

      // R5 event between read and write
      rd(RA, r);
      pulse();
      wr(RA, 32'h40);
      rd(RA, r);
      chk("R5 event between", r, 32'hC0);

      // R5 same-cycle event and write
      @(negedge clk);
      @(negedge clk);
      bus_wdata = 32'h40; bus_wr = 1'b1; chan_evt = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; chan_evt = 1'b0;
      rd(RA, r);
      chk("R5 same cycle", r, 32'hC0);
      wr(RA, 32'h40);
      rd(RA, r);
      chk("R5 later clear", r, 32'h40);

      // R9 with crst_en off
      wr(RA, 32'h00);
      @(negedge clk); chan_evt = 1'b1; #1;
      chk("R9 disabled", {31'd0, ctr_rst}, 32'd0);
      @(negedge clk); chan_evt = 1'b0;

      // R10 reset clears flag
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      rd(RA, r);
      chk("R10 reset after flag", r, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule